// File: doc/BRIEF.md
# Burst Address Generator

This block produces the byte address of every beat of a memory-bus burst. A load strobe captures a start address, a three-bit burst type and a three-bit transfer size. Each later advance strobe moves the held address to the next beat and adds one to the beat count. The surrounding bus logic decides when to load and when to advance. This block only reports the current beat's address, its index within the burst, and whether that beat is the final one of a fixed-length burst.

The block supports single transfers, incrementing bursts with no preset length, and fixed bursts of 4, 8 or 16 beats. Each fixed length comes in an incrementing form and a wrapping form. A wrapping burst keeps its address inside an aligned window whose size is the beat count times the transfer size in bytes. All outputs are registered and change on the clock edge after the strobe that caused them.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, addr_o is 0, beat_o is 0 and last_o is 0. Advance strobes are ignored until the first load.
- R2: A load puts start_addr_i on addr_o and 0 on beat_o in the next cycle. last_o then reads 1 only when the loaded burst type is the single transfer.
- R3: The burst type encodes as follows: 000 single, 001 incrementing of open length, 010 wrap-4, 011 incr-4, 100 wrap-8, 101 incr-8, 110 wrap-16, 111 incr-16.
- R4: The address step per beat is 2 to the power of size_i bytes. For example, 000 is 1 byte, 001 is a 2-byte halfword and 010 is a 4-byte word.
- R5: For incrementing types, each accepted advance adds the step to the address with no boundary, modulo 2^ADDR_W. A word incr-4 from 0x38 gives 0x38, 0x3C, 0x40, 0x44.
- R6: For wrapping types, the window is beats times step bytes. The next address keeps the bits above the window and replaces the bits inside it with (low part + step) modulo the window. A word wrap-4 goes from 0x3C to 0x30, and a word wrap-8 goes from 0x3C to 0x20.
- R7: Each accepted advance adds one to beat_o, modulo 2^CNT_W.
- R8: For single and fixed-length types, last_o is 1 exactly when beat_o equals the burst length minus one. It is never 1 for the open-length incrementing type.
- R9: An advance while last_o is 1 is ignored, and addr_o and beat_o hold.
- R10: With neither strobe high, addr_o, beat_o and last_o hold.
- R11: When load and advance are both high in the same cycle, the load takes effect and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture a new burst |
| start_addr_i | input | ADDR_W | First beat address |
| burst_i | input | 3 | Burst type code (R3) |
| size_i | input | 3 | Transfer size code (R4) |
| adv_i | input | 1 | Move to the next beat |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | CNT_W | Current beat index |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach is the fold of a wrapping burst that starts partway through its window, combined with an advance that arrives on the last beat. There the address must stay at the wrapped value rather than fold again. The stimulus reaches this by sweeping every burst type and each size from byte to word, over start addresses that sit mid-window, at a window's top, and just under the top of the address space. Each burst is advanced two beats past its length, and an idle cycle and a simultaneous load-and-advance are mixed in.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [2:0] {
    BT_SINGLE = 3'b000,
    BT_INCR   = 3'b001,
    BT_WRAP4  = 3'b010,
    BT_INCR4  = 3'b011,
    BT_WRAP8  = 3'b100,
    BT_INCR8  = 3'b101,
    BT_WRAP16 = 3'b110,
    BT_INCR16 = 3'b111
  } burst_t;

  typedef struct packed {
    logic       fixed;   // has a preset length (single included)
    logic       wrap;    // folds inside an aligned window
    logic [2:0] lg_len;  // log2 of beat count for fixed types
  } burst_info_t;

  function automatic burst_info_t decode_burst(input logic [2:0] code);
    burst_info_t r;
    r.fixed  = (code != BT_INCR);
    r.wrap   = (code != BT_SINGLE) && (code[0] == 1'b0);
    r.lg_len = (code[2:1] == 2'b00) ? 3'd0 : {1'b0, code[2:1]} + 3'd1;
    return r;
  endfunction

endpackage

// File: rtl/bag_step.sv
module bag_step #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        size_i,
  output logic [ADDR_W-1:0] step_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  assign step_o = ONE << size_i;

  always_comb begin
    assert_step_onehot_R4: assert ($countones(step_o) == 1 || ADDR_W <= 7);
  end
endmodule

// File: rtl/bag_wrap_mask.sv
module bag_wrap_mask #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        lg_len_i,
  input  logic [2:0]        size_i,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int SUM_W = 8;
  logic [SUM_W-1:0] lg_win;

  assign lg_win = SUM_W'(lg_len_i) + SUM_W'(size_i);

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign mask_o[g] = (SUM_W'(g) < lg_win);
  end
endmodule

// File: rtl/bag_next.sv
module bag_next #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] sum;

  assign sum    = addr_i + step_i;
  assign next_o = wrap_i ? ((addr_i & ~mask_i) | (sum & mask_i)) : sum;
endmodule

// File: rtl/bag_beat.sv
module bag_beat #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             fixed_i,
  input  logic [2:0]       lg_len_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             fixed_q;
  logic [2:0]       lg_q;
  logic [CNT_W-1:0] beat_n;
  logic [CNT_W-1:0] len_m1;

  assign beat_n = beat_o + ONE;
  assign len_m1 = (ONE << lg_q) - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_o  <= '0;
      last_o  <= 1'b0;
      fixed_q <= 1'b0;
      lg_q    <= 3'd0;
    end else if (load_i) begin
      beat_o  <= '0;
      fixed_q <= fixed_i;
      lg_q    <= lg_len_i;
      last_o  <= fixed_i && (lg_len_i == 3'd0);
    end else if (step_i) begin
      beat_o  <= beat_n;
      last_o  <= fixed_q && (beat_n == len_m1);
    end
  end

  assert_beat_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (beat_o == $past(beat_o) + ONE));

  assert_load_zero_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_o == '0));

  assert_last_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    last_o |-> (beat_o == len_m1));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        burst_i,
  input  logic [2:0]        size_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  beat_o,
  output logic              last_o
);
  import bag_pkg::*;

  burst_info_t       info_in;
  logic              wrap_q;
  logic              fixed_q;
  logic [2:0]        lg_q;
  logic [2:0]        size_q;
  logic              idle_q;
  logic              accept;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] next_addr;

  assign info_in = decode_burst(burst_i);
  assign accept  = adv_i && !load_i && !idle_q && !last_o;

  bag_step #(.ADDR_W(ADDR_W)) u_step (
    .size_i (size_q),
    .step_o (step)
  );

  bag_wrap_mask #(.ADDR_W(ADDR_W)) u_mask (
    .lg_len_i (lg_q),
    .size_i   (size_q),
    .mask_o   (mask)
  );

  bag_next #(.ADDR_W(ADDR_W)) u_next (
    .addr_i (addr_o),
    .step_i (step),
    .mask_i (mask),
    .wrap_i (wrap_q),
    .next_o (next_addr)
  );

  bag_beat #(.CNT_W(CNT_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .fixed_i  (info_in.fixed),
    .lg_len_i (info_in.lg_len),
    .step_i   (accept),
    .beat_o   (beat_o),
    .last_o   (last_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wrap_q  <= 1'b0;
      fixed_q <= 1'b0;
      lg_q    <= 3'd0;
      size_q  <= 3'd0;
      idle_q  <= 1'b1;
    end else if (load_i) begin
      addr_o  <= start_addr_i;
      wrap_q  <= info_in.wrap;
      fixed_q <= info_in.fixed;
      lg_q    <= info_in.lg_len;
      size_q  <= size_i;
      idle_q  <= 1'b0;
    end else if (accept) begin
      addr_o  <= next_addr;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (idle_q && !load_i) |=> (addr_o == '0 && beat_o == '0 && !last_o));

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(start_addr_i)));

  assert_incr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !wrap_q) |=> (addr_o == $past(addr_o) + $past(step)));

  assert_wrap_window_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && wrap_q) |=> ((addr_o & ~$past(mask)) == ($past(addr_o) & ~$past(mask))));

  assert_open_no_last_R8: assert property (@(posedge clk) disable iff (rst)
    !fixed_q |-> !last_o);

  assert_hold_last_R9: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && last_o) |=> ($stable(addr_o) && $stable(beat_o)));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> ($stable(addr_o) && $stable(beat_o) && $stable(last_o)));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [2:0]        burst_i = 3'd0;
  logic [2:0]        size_i = 3'd0;
  logic              adv_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic [CNT_W-1:0]  beat_o;
  logic              last_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // model state
  logic [ADDR_W-1:0] e_addr;
  int                e_beat;
  bit                e_last;
  bit                e_fixed;
  bit                e_wrap;
  int                e_len;
  int                e_size;
  bit                e_idle;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .start_addr_i(start_addr_i),
    .burst_i(burst_i), .size_i(size_i), .adv_i(adv_i),
    .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string areq);
    check(areq, longint'(addr_o), longint'(e_addr));
    check("R7 beat", longint'(beat_o), longint'(e_beat));
    check("R8 last", longint'(last_o), longint'(e_last));
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input int bt, input int sz, input bit with_adv);
    @(negedge clk);
    load_i = 1'b1; start_addr_i = a; burst_i = 3'(bt); size_i = 3'(sz); adv_i = with_adv;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
    e_addr  = a;
    e_beat  = 0;
    e_size  = sz;
    e_fixed = (bt != 1);
    e_wrap  = (bt != 0) && (bt % 2 == 0);
    e_len   = (bt < 2) ? 1 : (1 << (bt / 2 + 1));
    e_last  = e_fixed && (e_len == 1);
    e_idle  = 1'b0;
    check(with_adv ? "R11 load wins" : "R2 load addr", longint'(addr_o), longint'(e_addr));
    check("R2 beat zero", longint'(beat_o), 0);
    check("R2 R8 last at load", longint'(last_o), longint'(e_last));
  endtask

  task automatic do_adv();
    longint unsigned st, bnd, lo, cur;
    bit held;
    @(negedge clk);
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
    held = e_last || e_idle;
    if (!held) begin
      st  = longint'(1) << e_size;
      cur = longint'(e_addr);
      if (e_wrap) begin
        bnd = st * longint'(e_len);
        lo  = cur % bnd;
        e_addr = ADDR_W'((cur - lo) + ((lo + st) % bnd));
      end else begin
        e_addr = ADDR_W'(cur + st);
      end
      e_beat = (e_beat + 1) % (1 << CNT_W);
      e_last = e_fixed && (e_beat == e_len - 1);
    end
    if (held)        check_all("R9 hold on last");
    else if (e_wrap) check_all("R6 R3 R4 wrap addr");
    else             check_all("R5 R3 R4 incr addr");
  endtask

  task automatic quiet();
    @(negedge clk);
    @(negedge clk);
    check_all("R10 quiet hold");
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] addrs [4];
    addrs[0] = 32'h0000_0038;
    addrs[1] = 32'h0000_003C;
    addrs[2] = 32'h0000_1000;
    addrs[3] = 32'hFFFF_FFF8;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset addr", longint'(addr_o), 0);
    check("R1 reset beat", longint'(beat_o), 0);
    check("R1 reset last", longint'(last_o), 0);
    e_addr = '0; e_beat = 0; e_last = 1'b0; e_idle = 1'b1;
    e_fixed = 1'b0; e_wrap = 1'b0; e_len = 1; e_size = 0;
    do_adv();
    check("R1 adv ignored", longint'(addr_o), 0);

    // directed examples
    do_load(32'h38, 3, 2, 1'b0);
    do_adv(); check("R5 incr4 0x3C", longint'(addr_o), 32'h3C);
    do_adv(); check("R5 incr4 0x40", longint'(addr_o), 32'h40);
    do_adv(); check("R5 incr4 0x44", longint'(addr_o), 32'h44);
    check("R8 incr4 last", longint'(last_o), 1);
    do_adv(); check("R9 held", longint'(addr_o), 32'h44);

    do_load(32'h3C, 2, 2, 1'b0);
    do_adv(); check("R6 wrap4 fold", longint'(addr_o), 32'h30);
    do_load(32'h3C, 4, 2, 1'b0);
    do_adv(); check("R6 wrap8 fold", longint'(addr_o), 32'h20);
    do_load(32'h10, 4, 1, 1'b0);
    do_adv(); check("R4 halfword step", longint'(addr_o), 32'h12);

    // priority: load with advance in a burst
    do_adv();
    do_load(32'h200, 5, 0, 1'b1);

    // sweep
    for (int bt = 0; bt < 8; bt++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int ai = 0; ai < 4; ai++) begin
          int n;
          do_load(addrs[ai], bt, sz, 1'b0);
          n = (bt == 1) ? 20 : e_len + 2;
          for (int k = 0; k < n; k++) begin
            do_adv();
            if (k == 1) quiet();
          end
        end
      end
    end

    // open-length counter runs past 2^CNT_W beats
    do_load(32'h0, 1, 0, 1'b0);
    for (int k = 0; k < 70; k++) do_adv();
    check("R7 count wrap", longint'(beat_o), 70 % 64);
    check("R8 open never last", longint'(last_o), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule